// File: doc/BRIEF.md
# Bus Width Negotiator and Byte Splitter

This block sits on the master side of a backplane whose slaves may be 8 or 16 bits wide. The CPU side hands it one access at a time through a request/response port. For a 16-bit request the block drives the active-low wide-transfer status and watches the slave's active-low wide acknowledge for a fixed window of clocks. An acknowledge inside the window gives a single 16-bit data cycle. The low byte travels on the data-out lane and the high byte on the data-in lane, which the master drives during writes.

If the window closes with no acknowledge, the block falls back to two 8-bit cycles: the low byte at the even address, then the high byte at the next address. A read result is put back together into one 16-bit word. Legacy boards never acknowledge, so they always get byte cycles. When the fallback is disabled for the access, the block pulses the active-low error line for one clock instead and completes the request with an error flag. A plain 8-bit request runs one byte cycle at its exact address.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_done` is 0, `bus_wide_n` and `bus_error_n` are 1, and neither `bus_rd` nor `bus_wr` is asserted.
- R2: A 16-bit request (`req_wide`=1) accepted on a clock edge drives `bus_wide_n` low from the next cycle onward. `bus_start` is high only in that first cycle, and `bus_addr` holds the request address with bit 0 cleared.
- R3: If `bus_wide_ack_n` is sampled low in any of the first WIN clocks after acceptance, exactly one data cycle follows with `bus_wide_n` still low. In that cycle `bus_dout` carries bits 7:0 and `bus_din_o` carries bits 15:8, and `bus_din_oe` is 1 only for writes.
- R4: A 16-bit read cycle returns `resp_rdata` = {`bus_din_i`, `bus_dout_i`} as sampled in that data cycle.
- R5: If no acknowledge is seen within WIN clocks and `split_en` was 1 at acceptance, two byte cycles follow with `bus_wide_n` high. Each cycle has a `bus_start` pulse. The first uses the even address and the second uses the even address plus one.
- R6: A split read returns the first byte cycle's `bus_din_i` in bits 7:0 and the second byte cycle's `bus_din_i` in bits 15:8.
- R7: A split write drives write-data bits 7:0 on `bus_dout` in the first byte cycle and bits 15:8 in the second. `bus_din_oe` stays 0.
- R8: If no acknowledge is seen within WIN clocks and `split_en` was 0, `bus_error_n` goes low for exactly one clock and no data cycle runs. The next cycle brings `resp_done`=1 together with `resp_err`=1.
- R9: An 8-bit request (`req_wide`=0) never drives `bus_wide_n` low. It runs one byte cycle at the exact request address, and a read returns {8'h00, `bus_din_i`}.
- R10: `resp_done` is a one-clock pulse in the cycle after the last bus cycle. `req_ready` drops in the cycle after acceptance and stays low until then.
- R11: An acknowledge first seen in the last clock of the window still selects the 16-bit cycle. One that first arrives a clock later is ignored, and the access is split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| split_en | input | 1 | 1 = fall back to byte cycles, 0 = flag an error |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data (8-bit writes use bits 7:0) |
| resp_done | output | 1 | One-clock completion pulse |
| resp_err | output | 1 | Completion with width error, valid with `resp_done` |
| resp_rdata | output | 16 | Read result, valid with `resp_done` |
| bus_start | output | 1 | Bus cycle start strobe |
| bus_addr | output | AW | Bus address |
| bus_wide_n | output | 1 | Active-low 16-bit transfer request status |
| bus_wide_ack_n | input | 1 | Active-low slave acknowledge of 16-bit capability |
| bus_error_n | output | 1 | Active-low error line |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_dout | output | 8 | Data-out lane (low byte) |
| bus_dout_i | input | 8 | Data-out lane as driven by a 16-bit slave on reads |
| bus_din_o | output | 8 | Data-in lane driven by the master on 16-bit writes |
| bus_din_oe | output | 1 | Enable for `bus_din_o` |
| bus_din_i | input | 8 | Data-in lane from the slave |

## Verification
The bench builds the block with WIN=2 and AW=16. A window of two clocks makes it cheap to place the slave's acknowledge at one, two and three clocks after the status goes low. That covers an early acknowledge, one on the last window clock and one that arrives too late. A modelled slave returns an address-derived byte and can be switched between 8-bit and 16-bit behaviour. This lets the same words be read through both the wide path and the split path, and lets the bench check the error path against a legacy slave.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEGOT,
        ST_WIDE,
        ST_LO,
        ST_HI,
        ST_BYTE,
        ST_ERR
    } bws_state_e;

    typedef struct packed {
        logic              write;
        logic              wide;
        logic              split;
        logic [WORD_W-1:0] wdata;
    } bws_req_t;

    function automatic logic [BYTE_W-1:0] low_lane(input logic [WORD_W-1:0] w);
        return w[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] high_lane(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/bws_window.sv
module bws_window #(
    parameter int WIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack_n,
    output logic first,
    output logic last,
    output logic ack_hit
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(WIN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign first   = run && (cnt == '0);
    assign last    = run && (cnt == CW'(WIN - 1));
    assign ack_hit = run && !ack_n;
endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
    import bws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_wide,
    input  logic             split_en,
    input  logic [AW-1:0]    req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic             win_last,
    input  logic             win_ack,
    output bws_state_e       state,
    output bws_req_t         cur,
    output logic [AW-1:0]    cur_addr,
    output logic             resp_done,
    output logic             resp_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_addr  <= '0;
            resp_done <= 1'b0;
            resp_err  <= 1'b0;
        end else begin
            resp_done <= 1'b0;
            resp_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.write <= req_write;
                        cur.wide  <= req_wide;
                        cur.split <= split_en;
                        cur.wdata <= req_wdata;
                        cur_addr  <= req_addr;
                        state     <= req_wide ? ST_NEGOT : ST_BYTE;
                    end
                end
                ST_NEGOT: begin
                    if (win_ack) begin
                        state <= ST_WIDE;
                    end else if (win_last) begin
                        state <= cur.split ? ST_LO : ST_ERR;
                    end
                end
                ST_LO: state <= ST_HI;
                ST_WIDE, ST_HI, ST_BYTE: begin
                    state     <= ST_IDLE;
                    resp_done <= 1'b1;
                end
                ST_ERR: begin
                    state     <= ST_IDLE;
                    resp_done <= 1'b1;
                    resp_err  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bws_lanes.sv
module bws_lanes
    import bws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bws_state_e        state,
    input  bws_req_t          cur,
    input  logic [AW-1:0]     cur_addr,
    input  logic              win_first,
    input  logic [BYTE_W-1:0] bus_dout_i,
    input  logic [BYTE_W-1:0] bus_din_i,
    output logic              bus_start,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_wide_n,
    output logic              bus_error_n,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BYTE_W-1:0] bus_dout,
    output logic [BYTE_W-1:0] bus_din_o,
    output logic              bus_din_oe,
    output logic [WORD_W-1:0] rdata
);
    logic [AW-1:0] even_addr;
    logic          data_phase;

    assign even_addr  = {cur_addr[AW-1:1], 1'b0};
    assign data_phase = (state == ST_WIDE) || (state == ST_LO) ||
                        (state == ST_HI)   || (state == ST_BYTE);

    always_comb begin
        bus_start   = 1'b0;
        bus_addr    = '0;
        bus_wide_n  = 1'b1;
        bus_error_n = 1'b1;
        bus_dout    = '0;
        bus_din_o   = '0;
        bus_din_oe  = 1'b0;
        bus_rd      = data_phase && !cur.write;
        bus_wr      = data_phase && cur.write;
        unique case (state)
            ST_NEGOT: begin
                bus_start  = win_first;
                bus_wide_n = 1'b0;
                bus_addr   = even_addr;
            end
            ST_WIDE: begin
                bus_wide_n = 1'b0;
                bus_addr   = even_addr;
                bus_dout   = low_lane(cur.wdata);
                bus_din_o  = high_lane(cur.wdata);
                bus_din_oe = cur.write;
            end
            ST_LO: begin
                bus_start = 1'b1;
                bus_addr  = even_addr;
                bus_dout  = low_lane(cur.wdata);
            end
            ST_HI: begin
                bus_start = 1'b1;
                bus_addr  = even_addr | AW'(1);
                bus_dout  = high_lane(cur.wdata);
            end
            ST_BYTE: begin
                bus_start = 1'b1;
                bus_addr  = cur_addr;
                bus_dout  = low_lane(cur.wdata);
            end
            ST_ERR:  bus_error_n = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (!cur.write) begin
            unique case (state)
                ST_WIDE: rdata <= {bus_din_i, bus_dout_i};
                ST_LO:   rdata[BYTE_W-1:0] <= bus_din_i;
                ST_HI:   rdata[WORD_W-1:BYTE_W] <= bus_din_i;
                ST_BYTE: rdata <= {{(WORD_W-BYTE_W){1'b0}}, bus_din_i};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int AW  = 16,
    parameter int WIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic          split_en,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic          resp_done,
    output logic          resp_err,
    output logic [15:0]   resp_rdata,
    output logic          bus_start,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wide_n,
    input  logic          bus_wide_ack_n,
    output logic          bus_error_n,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [7:0]    bus_dout,
    input  logic [7:0]    bus_dout_i,
    output logic [7:0]    bus_din_o,
    output logic          bus_din_oe,
    input  logic [7:0]    bus_din_i
);
    bws_state_e    state;
    bws_req_t      cur;
    logic [AW-1:0] cur_addr;
    logic          win_first, win_last, win_ack;

    assign req_ready = (state == ST_IDLE);

    bws_window #(.WIN(WIN)) u_window (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_NEGOT),
        .ack_n   (bus_wide_ack_n),
        .first   (win_first),
        .last    (win_last),
        .ack_hit (win_ack)
    );

    bws_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .split_en  (split_en),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .win_last  (win_last),
        .win_ack   (win_ack),
        .state     (state),
        .cur       (cur),
        .cur_addr  (cur_addr),
        .resp_done (resp_done),
        .resp_err  (resp_err)
    );

    bws_lanes #(.AW(AW)) u_lanes (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .cur         (cur),
        .cur_addr    (cur_addr),
        .win_first   (win_first),
        .bus_dout_i  (bus_dout_i),
        .bus_din_i   (bus_din_i),
        .bus_start   (bus_start),
        .bus_addr    (bus_addr),
        .bus_wide_n  (bus_wide_n),
        .bus_error_n (bus_error_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_dout    (bus_dout),
        .bus_din_o   (bus_din_o),
        .bus_din_oe  (bus_din_oe),
        .rdata       (resp_rdata)
    );
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_done,
    input logic          resp_err,
    input logic          bus_wide_n,
    input logic          bus_error_n,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_din_oe,
    input logic [AW-1:0] bus_addr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(bus_rd || bus_wr) && bus_wide_n);

    p_wide_even_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wide_n |-> (bus_addr[0] == 1'b0));

    p_oe_wide_write_r3: assert property (@(posedge clk) disable iff (rst)
        bus_din_oe |-> !bus_wide_n && bus_wr);

    p_err_one_clk_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_error_n |=> bus_error_n);

    p_err_completes_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_error_n |=> resp_done && resp_err);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
endmodule

bind bus_width_splitter bws_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_done   (resp_done),
    .resp_err    (resp_err),
    .bus_wide_n  (bus_wide_n),
    .bus_error_n (bus_error_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_din_oe  (bus_din_oe),
    .bus_addr    (bus_addr)
);

// File: tb/bus_width_splitter_tb.sv
module bus_width_splitter_tb;
    localparam int AW = 16;
    localparam int WIN = 2;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, split_en = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ready, resp_done, resp_err;
    logic [15:0]   resp_rdata;
    logic          bus_start, bus_wide_n, bus_wide_ack_n, bus_error_n, bus_rd, bus_wr, bus_din_oe;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_dout, bus_dout_i, bus_din_o, bus_din_i;

    int errors = 0;
    int checks = 0;

    logic slave_wide = 1'b0;
    int   ack_delay  = 1;
    int   lowcnt = 0;
    int   n_start = 0, n_strb = 0, n_errlow = 0, n_widelow = 0;
    int   base_strb = 0;
    logic [AW-1:0] s_addr [2];
    logic [7:0]    s_dout [2];
    logic [7:0]    s_dino [2];
    logic          s_oe   [2];
    logic          s_wide [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bmem(input logic [AW-1:0] a);
        return (a[7:0] * 8'd3) ^ 8'h5A;
    endfunction

    assign bus_wide_ack_n = !(slave_wide && !bus_wide_n && (lowcnt >= ack_delay));
    assign bus_dout_i     = bmem(bus_addr);
    assign bus_din_i      = (slave_wide && !bus_wide_n) ? bmem(bus_addr | AW'(1)) : bmem(bus_addr);

    bus_width_splitter #(.AW(AW), .WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .split_en(split_en),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
        .resp_err(resp_err), .resp_rdata(resp_rdata), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_wide_n(bus_wide_n), .bus_wide_ack_n(bus_wide_ack_n),
        .bus_error_n(bus_error_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_dout_i(bus_dout_i), .bus_din_o(bus_din_o),
        .bus_din_oe(bus_din_oe), .bus_din_i(bus_din_i)
    );

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!bus_wide_n) begin
            lowcnt    <= lowcnt + 1;
            n_widelow <= n_widelow + 1;
        end else begin
            lowcnt <= 0;
        end
        if (bus_start) n_start <= n_start + 1;
        if (!bus_error_n) n_errlow <= n_errlow + 1;
        if (bus_rd || bus_wr) begin
            if (n_strb - base_strb < 2) begin
                s_addr[n_strb - base_strb] <= bus_addr;
                s_dout[n_strb - base_strb] <= bus_dout;
                s_dino[n_strb - base_strb] <= bus_din_o;
                s_oe[n_strb - base_strb]   <= bus_din_oe;
                s_wide[n_strb - base_strb] <= !bus_wide_n;
            end
            n_strb <= n_strb + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int d_start, d_strb, d_err, d_wlow;

    task automatic run_txn(input logic wr, input logic wide, input logic spl,
                           input logic [AW-1:0] a, input logic [15:0] wd);
        int b_start, b_err, b_wlow;
        bit seen;
        @(negedge clk);
        b_start = n_start; b_err = n_errlow; b_wlow = n_widelow;
        base_strb = n_strb;
        req_valid = 1'b1; req_write = wr; req_wide = wide; split_en = spl;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", {31'b0, req_ready}, 32'd0);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (resp_done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R10 completion seen", {31'b0, seen}, 32'd1);
        d_start = n_start - b_start;
        d_strb  = n_strb - base_strb;
        d_err   = n_errlow - b_err;
        d_wlow  = n_widelow - b_wlow;
    endtask

    task automatic check_done_pulse();
        @(negedge clk);
        chk("R10 done is one pulse", {31'b0, resp_done}, 32'd0);
        chk("R10 ready again", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 done", {31'b0, resp_done}, 32'd0);
        chk("R1 wide_n", {31'b0, bus_wide_n}, 32'd1);
        chk("R1 error_n", {31'b0, bus_error_n}, 32'd1);
        chk("R1 strobes", {30'b0, bus_rd, bus_wr}, 32'd0);
    endtask

    task automatic t_wide_read();
        slave_wide = 1'b1; ack_delay = 1;
        run_txn(1'b0, 1'b1, 1'b1, 16'h1235, 16'h0);
        chk("R2 single start pulse", d_start, 1);
        chk("R3 one data cycle", d_strb, 1);
        chk("R3 data cycle wide", {31'b0, s_wide[0]}, 32'd1);
        chk("R2 even address", s_addr[0], 32'h1234);
        chk("R4 wide read data", resp_rdata, {bmem(16'h1235), bmem(16'h1234)});
        chk("R4 no error", {31'b0, resp_err}, 32'd0);
        check_done_pulse();
    endtask

    task automatic t_wide_write_last_clock();
        slave_wide = 1'b1; ack_delay = 2;
        run_txn(1'b1, 1'b1, 1'b1, 16'h0040, 16'hBEEF);
        chk("R11 ack on last window clock gives wide", d_strb, 1);
        chk("R11 wide data cycle", {31'b0, s_wide[0]}, 32'd1);
        chk("R3 low lane on dout", s_dout[0], 32'hEF);
        chk("R3 high lane on din", s_dino[0], 32'hBE);
        chk("R3 din driven on write", {31'b0, s_oe[0]}, 32'd1);
        check_done_pulse();
    endtask

    task automatic t_split_read_late_ack();
        slave_wide = 1'b1; ack_delay = 3;
        run_txn(1'b0, 1'b1, 1'b1, 16'h2A11, 16'h0);
        chk("R11 late ack ignored, split", d_strb, 2);
        chk("R5 starts: window + two bytes", d_start, 3);
        chk("R5 first byte narrow", {31'b0, s_wide[0]}, 32'd0);
        chk("R5 second byte narrow", {31'b0, s_wide[1]}, 32'd0);
        chk("R5 first address even", s_addr[0], 32'h2A10);
        chk("R5 second address odd", s_addr[1], 32'h2A11);
        chk("R6 reassembled read", resp_rdata, {bmem(16'h2A11), bmem(16'h2A10)});
        check_done_pulse();
    endtask

    task automatic t_split_write_legacy();
        slave_wide = 1'b0; ack_delay = 1;
        run_txn(1'b1, 1'b1, 1'b1, 16'h0102, 16'h1357);
        chk("R5 two byte cycles", d_strb, 2);
        chk("R5 low address", s_addr[0], 32'h0102);
        chk("R5 high address", s_addr[1], 32'h0103);
        chk("R7 low byte first", s_dout[0], 32'h57);
        chk("R7 high byte second", s_dout[1], 32'h13);
        chk("R7 din not driven", {30'b0, s_oe[0], s_oe[1]}, 32'd0);
        chk("R5 no error", {31'b0, resp_err}, 32'd0);
        check_done_pulse();
    endtask

    task automatic t_error_no_split();
        slave_wide = 1'b0;
        run_txn(1'b0, 1'b1, 1'b0, 16'h0300, 16'h0);
        chk("R8 error low one clock", d_err, 1);
        chk("R8 no data cycle", d_strb, 0);
        chk("R8 error flag", {31'b0, resp_err}, 32'd1);
        check_done_pulse();
    endtask

    task automatic t_byte_access();
        slave_wide = 1'b1; ack_delay = 1;
        run_txn(1'b0, 1'b0, 1'b1, 16'h0777, 16'h0);
        chk("R9 status never low", d_wlow, 0);
        chk("R9 one byte cycle", d_strb, 1);
        chk("R9 exact address", s_addr[0], 32'h0777);
        chk("R9 read zero-extended", resp_rdata, {8'h00, bmem(16'h0777)});
        check_done_pulse();
        run_txn(1'b1, 1'b0, 1'b0, 16'h0009, 16'hAA3C);
        chk("R9 write one cycle", d_strb, 1);
        chk("R9 write low byte", s_dout[0], 32'h3C);
        chk("R9 write no error", {31'b0, resp_err}, 32'd0);
        check_done_pulse();
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_wide_read();
                t_wide_write_last_clock();
                t_split_read_late_ack();
                t_split_write_legacy();
                t_error_no_split();
                t_byte_access();
            end
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule